// File: doc/BRIEF.md
# Event-Reloaded Watchdog Timer with Selectable Time Unit

This block is a watchdog counter controlled through four byte-wide registers. A reload value of up to 16 bits starts the count. The count then falls by one for every tick from an external seconds prescaler, or for every sixtieth tick when minutes are selected. A nonzero write to the value registers starts the watchdog, and a zero write stops it. Software keeps the watchdog alive by writing the value again. Chosen peripheral events can also keep it alive: a game-port read, an IR data-port write, or a keyboard or mouse interrupt. Each event reloads the counter after a short fixed delay.

When the count reaches zero, or when software forces an expiry, the block sets a sticky status flag and stops counting. It can also drive a reset pulse, pull power-good low for a fixed pulse, and raise an interrupt. The parameter `WIDE_VALUE` chooses a 16-bit or an 8-bit count. With the 8-bit count the high value register reads zero and ignores writes.

Register addresses: 0 control, 1 configuration, 2 value low byte, 3 value high byte.

Top module: `wdt_unit`

## Requirements
- R1: After reset every register reads 0, `rst_out` and `irq_out` are 0, `pwr_good` is 1, and ticks cause no expiry.
- R2: With configuration bit 7 set (seconds), writing a nonzero value N starts the count. The status flag (control bit 0) is set by the edge that samples the Nth tick, and not before.
- R3: With configuration bit 7 clear (minutes), the count falls once per 60 ticks, so a value of N expires on tick 60*N. A divide-by-60 sub-count clears on every reload.
- R4: Writing a value of zero stops the watchdog, and no number of ticks sets the status flag.
- R5: A pulse on an event input reloads the counter with the value registers `RELOAD_DELAY` cycles after it is sampled. It does so only while its enable bit in the control register is set: bit 7 for an IR write, bit 6 for a mouse interrupt, bit 5 for a keyboard interrupt, bit 4 for a game-port read.
- R6: An event whose enable bit is clear has no effect on when the count expires.
- R7: Once set, the status flag stays set until a control-register write with bit 0 at 0. A control write with bit 0 at 1 leaves it set.
- R8: A control write with bit 1 set expires the watchdog on that edge, exactly as a natural expiry does. Bit 1 always reads 0.
- R9: On expiry `rst_out` is high for exactly `PULSE_LEN` (16) cycles when configuration bit 6 is set. `pwr_good` is low for the same cycles when configuration bit 4 is set. With either bit clear, that output stays inactive.
- R10: `irq_out` is high while the status flag and configuration bit 5 are both set.
- R11: After an expiry the counter stays stopped: further ticks do not expire it again until a reload.
- R12: Control bits 7:4 and the whole configuration register read back as written. `irq_sel` shows configuration bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| sec_tick | input | 1 | One-cycle seconds tick from the prescaler |
| ev_gp_rd | input | 1 | Game-port read event |
| ev_ir_wr | input | 1 | IR data-port write event |
| ev_kbd_irq | input | 1 | Keyboard interrupt event |
| ev_mouse_irq | input | 1 | Mouse interrupt event |
| rst_out | output | 1 | Reset pulse on expiry |
| pwr_good | output | 1 | Power-good, pulled low on expiry |
| irq_out | output | 1 | Timeout interrupt |
| irq_sel | output | 4 | Selected interrupt line |

## Verification
Register writes, ticks and a forced expiry all act on the clock edge that samples them. The status flag, the read data and the pulse outputs therefore change at that edge. The bench drives on the falling edge and reads at the next falling edge. An event reload lands `RELOAD_DELAY` edges after the event is sampled, so the bench waits one cycle more than that before it sends further ticks, and it judges the reload only by the tick on which expiry then occurs. The pulse length is measured by counting falling-edge samples from the expiry edge until `rst_out` drops.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_CFG    = 2'd1,
        ADDR_VAL_LO = 2'd2,
        ADDR_VAL_HI = 2'd3
    } wdt_addr_e;

    localparam int CTL_STATUS    = 0;
    localparam int CTL_FORCE     = 1;
    localparam int CTL_EN_LSB    = 4;
    localparam int CFG_SECONDS   = 7;
    localparam int CFG_RST_EN    = 6;
    localparam int CFG_IRQ_EN    = 5;
    localparam int CFG_PG_EN     = 4;
    localparam int TICKS_PER_MIN = 60;

    typedef struct packed {
        logic [3:0]  ev_en;   // [3] IR, [2] mouse, [1] keyboard, [0] game port
        logic        status;
        logic [7:0]  cfg;
        logic [7:0]  val_lo;
        logic [7:0]  val_hi;
        logic [15:0] cnt;
        logic [5:0]  sub;
        logic        armed;
    } wdt_state_t;

endpackage

// File: rtl/wdt_reload_delay.sv
module wdt_reload_delay #(
    parameter int DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic fire
);
    logic [DELAY-1:0] pipe_d, pipe_q;

    generate
        if (DELAY == 1) begin : g_single
            always_comb pipe_d = trig;
        end else begin : g_chain
            always_comb pipe_d = {pipe_q[DELAY-2:0], trig};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign fire = pipe_q[DELAY-1];
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (start)             cnt_d = CW'(LEN);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/wdt_unit.sv
module wdt_unit
    import wdt_pkg::*;
#(
    parameter bit WIDE_VALUE   = 1'b1,
    parameter int RELOAD_DELAY = 4,
    parameter int PULSE_LEN    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       sec_tick,
    input  logic       ev_gp_rd,
    input  logic       ev_ir_wr,
    input  logic       ev_kbd_irq,
    input  logic       ev_mouse_irq,
    output logic       rst_out,
    output logic       pwr_good,
    output logic       irq_out,
    output logic [3:0] irq_sel
);
    localparam logic [5:0] SUB_LAST = 6'(TICKS_PER_MIN - 1);

    wdt_state_t s_d, s_q;

    logic        ev_trig, reload_fire, pulse_active;
    logic        wr_ctrl, wr_cfg, wr_lo, wr_hi, val_wr;
    logic        step, force_exp, timeout;
    logic [15:0] reload_val, new_val;
    logic [3:0]  ev_vec;

    assign ev_vec  = {ev_ir_wr, ev_mouse_irq, ev_kbd_irq, ev_gp_rd};
    assign ev_trig = |(ev_vec & s_q.ev_en);

    wdt_reload_delay #(.DELAY(RELOAD_DELAY)) u_delay (
        .clk(clk), .rst_n(rst_n), .trig(ev_trig), .fire(reload_fire)
    );

    wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .start(timeout), .active(pulse_active)
    );

    always_comb begin
        wr_ctrl    = reg_wr && (reg_addr == ADDR_CTRL);
        wr_cfg     = reg_wr && (reg_addr == ADDR_CFG);
        wr_lo      = reg_wr && (reg_addr == ADDR_VAL_LO);
        wr_hi      = reg_wr && (reg_addr == ADDR_VAL_HI) && WIDE_VALUE;
        val_wr     = wr_lo || wr_hi;
        reload_val = {s_q.val_hi, s_q.val_lo};
        new_val    = wr_hi ? {reg_wdata, s_q.val_lo} : {s_q.val_hi, reg_wdata};
        step       = sec_tick && s_q.armed &&
                     (s_q.cfg[CFG_SECONDS] || (s_q.sub == SUB_LAST));
        force_exp  = wr_ctrl && reg_wdata[CTL_FORCE];
        timeout    = force_exp ||
                     (step && (s_q.cnt == 16'd1) && !val_wr && !reload_fire);

        s_d = s_q;

        // counting
        if (sec_tick && s_q.armed) begin
            if (!s_q.cfg[CFG_SECONDS])
                s_d.sub = (s_q.sub == SUB_LAST) ? 6'd0 : s_q.sub + 6'd1;
            if (step)
                s_d.cnt = s_q.cnt - 16'd1;
        end

        // delayed event reload
        if (reload_fire && (reload_val != 16'd0)) begin
            s_d.cnt   = reload_val;
            s_d.sub   = 6'd0;
            s_d.armed = 1'b1;
        end

        // register writes
        if (wr_ctrl) begin
            s_d.ev_en  = reg_wdata[7:CTL_EN_LSB];
            s_d.status = s_q.status & reg_wdata[CTL_STATUS];
        end
        if (wr_cfg) s_d.cfg = reg_wdata;
        if (wr_lo)  s_d.val_lo = reg_wdata;
        if (wr_hi)  s_d.val_hi = reg_wdata;
        if (val_wr) begin
            s_d.cnt   = new_val;
            s_d.sub   = 6'd0;
            s_d.armed = (new_val != 16'd0);
        end

        // expiry wins over everything
        if (timeout) begin
            s_d.status = 1'b1;
            s_d.armed  = 1'b0;
            s_d.cnt    = 16'd0;
            s_d.sub    = 6'd0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (reg_addr)
            ADDR_CTRL:   reg_rdata = {s_q.ev_en, 3'b000, s_q.status};
            ADDR_CFG:    reg_rdata = s_q.cfg;
            ADDR_VAL_LO: reg_rdata = s_q.val_lo;
            default:     reg_rdata = s_q.val_hi;
        endcase
    end

    assign rst_out  = pulse_active && s_q.cfg[CFG_RST_EN];
    assign pwr_good = !(pulse_active && s_q.cfg[CFG_PG_EN]);
    assign irq_out  = s_q.status && s_q.cfg[CFG_IRQ_EN];
    assign irq_sel  = s_q.cfg[3:0];

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.status && !wr_ctrl |=> s_q.status); // R7

    AST_EXPIRY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_active) |-> s_q.status); // R8

    AST_EXPIRY_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_active) |-> !s_q.armed); // R11

    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        reload_fire && (reload_val != 16'd0) && !val_wr && !timeout
        |=> s_q.cnt == $past(reload_val)); // R5

    AST_MINUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick && s_q.armed && !s_q.cfg[CFG_SECONDS] && (s_q.sub != SUB_LAST)
        && !reload_fire && !val_wr && !force_exp |=> $stable(s_q.cnt)); // R3
endmodule

// File: tb/wdt_unit_test.sv
module wdt_unit_test;
    localparam int DLY = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       sec_tick = 1'b0;
    logic       ev_gp_rd = 1'b0, ev_ir_wr = 1'b0, ev_kbd_irq = 1'b0, ev_mouse_irq = 1'b0;
    logic       rst_out, pwr_good, irq_out;
    logic [3:0] irq_sel;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    wdt_unit #(.WIDE_VALUE(1'b1), .RELOAD_DELAY(DLY), .PULSE_LEN(16)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
        .ev_gp_rd(ev_gp_rd), .ev_ir_wr(ev_ir_wr), .ev_kbd_irq(ev_kbd_irq),
        .ev_mouse_irq(ev_mouse_irq), .rst_out(rst_out), .pwr_good(pwr_good),
        .irq_out(irq_out), .irq_sel(irq_sel)
    );

    typedef struct packed {
        logic [7:0]  cfg;
        logic [15:0] value;
        logic [15:0] ticks;
        logic        exp_status;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'h80, 16'd3,   16'd2,   1'b0},
        '{8'h80, 16'd3,   16'd3,   1'b1},
        '{8'h80, 16'd1,   16'd1,   1'b1},
        '{8'h80, 16'd300, 16'd299, 1'b0},
        '{8'h80, 16'd256, 16'd256, 1'b1},
        '{8'h00, 16'd1,   16'd59,  1'b0},
        '{8'h00, 16'd1,   16'd60,  1'b1},
        '{8'h00, 16'd2,   16'd120, 1'b1},
        '{8'h80, 16'd0,   16'd40,  1'b0}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            sec_tick = 1'b1; @(negedge clk);
            sec_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_val(input logic [15:0] v);
        wr(2'd3, v[15:8]);
        wr(2'd2, v[7:0]);
    endtask

    function automatic logic status_bit();
        return 1'b0;
    endfunction

    logic [7:0] rv;

    task automatic get_status(output logic s);
        rd(2'd0, rv);
        s = rv[0];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic s;
        int   plen;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), rv);
            chk("R1 register reset", {8'h0, rv}, 16'h0);
        end
        chk("R1 rst_out", {15'h0, rst_out}, 16'h0);
        chk("R1 pwr_good", {15'h0, pwr_good}, 16'h1);
        chk("R1 irq_out", {15'h0, irq_out}, 16'h0);
        tick(3);
        get_status(s);
        chk("R1 no expiry when idle", {15'h0, s}, 16'h0);

        // table of count patterns: R2 seconds, R3 minutes, R4 zero value
        for (int v = 0; v < NV; v++) begin
            set_val(16'd0);
            wr(2'd0, 8'h00);
            wr(2'd1, VECS[v].cfg);
            set_val(VECS[v].value);
            tick(int'(VECS[v].ticks));
            get_status(s);
            if (VECS[v].value == 16'd0)  chk("R4 zero value stops", {15'h0, s}, {15'h0, VECS[v].exp_status});
            else if (VECS[v].cfg[7])     chk("R2 seconds expiry", {15'h0, s}, {15'h0, VECS[v].exp_status});
            else                         chk("R3 minutes expiry", {15'h0, s}, {15'h0, VECS[v].exp_status});
        end

        // R9 pulses disabled in cfg 0x80
        set_val(16'd0); wr(2'd0, 8'h00); wr(2'd1, 8'h80);
        set_val(16'd1);
        tick(1);
        chk("R9 rst_out stays low when disabled", {15'h0, rst_out}, 16'h0);
        chk("R9 pwr_good stays high when disabled", {15'h0, pwr_good}, 16'h1);

        // R7 sticky status
        wr(2'd0, 8'h01);
        get_status(s);
        chk("R7 status kept on write of 1", {15'h0, s}, 16'h1);
        idle(5);
        get_status(s);
        chk("R7 status held", {15'h0, s}, 16'h1);

        // R10 interrupt
        wr(2'd1, 8'hA3);
        chk("R10 irq with status and enable", {15'h0, irq_out}, 16'h1);
        wr(2'd1, 8'h80);
        chk("R10 irq without enable", {15'h0, irq_out}, 16'h0);
        wr(2'd0, 8'h00);
        get_status(s);
        chk("R7 status cleared by write of 0", {15'h0, s}, 16'h0);

        // R12 read-back
        wr(2'd0, 8'hF0);
        rd(2'd0, rv);
        chk("R12 control read-back", {8'h0, rv}, 16'h00F0);
        wr(2'd1, 8'hA5);
        rd(2'd1, rv);
        chk("R12 config read-back", {8'h0, rv}, 16'h00A5);
        chk("R12 irq_sel", {12'h0, irq_sel}, 16'h0005);
        set_val(16'h1234);
        rd(2'd3, rv);
        chk("R12 value high read-back", {8'h0, rv}, 16'h0012);

        // R9 pulse length and R11 stop after natural expiry
        set_val(16'd0); wr(2'd0, 8'h00); wr(2'd1, 8'hD0);
        set_val(16'd2);
        tick(1);
        sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
        chk("R9 pwr_good low in pulse", {15'h0, pwr_good}, 16'h0);
        plen = 0;
        while (rst_out && plen < 100) begin
            plen++;
            @(negedge clk);
        end
        chk("R9 reset pulse length", 16'(plen), 16'd16);
        chk("R9 pwr_good back high", {15'h0, pwr_good}, 16'h1);
        wr(2'd0, 8'h00);
        tick(5);
        get_status(s);
        chk("R11 stopped after expiry", {15'h0, s}, 16'h0);
        chk("R11 no second pulse", {15'h0, rst_out}, 16'h0);

        // R8 forced expiry
        set_val(16'd50);
        wr(2'd0, 8'h02);
        rd(2'd0, rv);
        chk("R8 force sets status, bit 1 reads 0", {8'h0, rv}, 16'h0001);
        chk("R8 force pulses rst_out", {15'h0, rst_out}, 16'h1);
        idle(20);
        wr(2'd0, 8'h00);
        tick(60);
        get_status(s);
        chk("R11 stopped after forced expiry", {15'h0, s}, 16'h0);

        // R5 enabled IR event reload
        wr(2'd1, 8'h80); wr(2'd0, 8'h80);
        set_val(16'd5);
        tick(3);
        ev_ir_wr = 1'b1; @(negedge clk); ev_ir_wr = 1'b0;
        idle(DLY + 1);
        tick(4);
        get_status(s);
        chk("R5 IR event reloaded count", {15'h0, s}, 16'h0);
        tick(1);
        get_status(s);
        chk("R5 expiry after reloaded count", {15'h0, s}, 16'h1);

        // R5 keyboard event reload
        wr(2'd0, 8'h20);
        set_val(16'd3);
        tick(2);
        ev_kbd_irq = 1'b1; @(negedge clk); ev_kbd_irq = 1'b0;
        idle(DLY + 1);
        tick(2);
        get_status(s);
        chk("R5 keyboard event reloaded count", {15'h0, s}, 16'h0);

        // R6 disabled events ignored (only game port enabled)
        set_val(16'd0);
        wr(2'd0, 8'h10);
        set_val(16'd3);
        tick(1);
        ev_ir_wr = 1'b1; ev_kbd_irq = 1'b1; ev_mouse_irq = 1'b1;
        @(negedge clk);
        ev_ir_wr = 1'b0; ev_kbd_irq = 1'b0; ev_mouse_irq = 1'b0;
        idle(DLY + 2);
        tick(1);
        get_status(s);
        chk("R6 no early expiry", {15'h0, s}, 16'h0);
        tick(1);
        get_status(s);
        chk("R6 disabled events did not reload", {15'h0, s}, 16'h1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule